// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter with Output Gate

This block forms two-channel digital audio subframes in the AES3 / IEC-60958 layout and sends them as a biphase-mark line code on a complementary output pair. Each subframe is built from one 24-bit sample plus its validity, user and channel-status flags. The block adds a preamble that marks the subframe type, then adds a parity bit, and encodes the result at one half-cell per clock. A source provides samples through a ready/valid handshake. The block asks for the next sample one clock before each subframe begins. Subframes alternate between left and right, starting with left. A block of frames restarts the start-of-block preamble.

An output gate sits between the encoder and the pins. Both pins are held low in these cases:
- while the reset is asserted;
- while a power-down or software-reset input is high;
- while a transmit-off input is high.

After a reset or hold, the pins stay low until the frame-sync input shows a rising edge. A bypass select sends an externally encoded stream to the pins in place of the internal encoder. The gate rules still apply in bypass.

Top module: `bmc_frame_tx`

## Requirements
- R1: While `rst_n` is low, and after its release until the first rising edge of `fsync`, both `tx_p` and `tx_n` are 0. `fsync` is sampled at each clock. A rising edge is a 1 that follows a 0, and the sample taken before any reset counts as a 1. The clock edge that samples the rising edge opens the gate, and the pins follow the selected source from the next edge on.
- R2: A subframe lasts 64 clocks, which is 32 slots of two half-cells each. Slots 0-3 hold the preamble. Slots 4-27 hold the sample, least significant bit first. Slot 28 holds V, slot 29 holds U and slot 30 holds C. Slot 31 is a parity bit that makes slots 4 to 31 hold an even number of ones.
- R3: In slots 4 to 31 the line level toggles at the first half-cell of every slot. It toggles again at the second half-cell only when the slot's bit is 1.
- R4: Preambles are eight half-cells that carry no per-slot toggle rule. Write the patterns with the first half-cell on the left, XOR them with the level that precedes the preamble, and they are: start-of-block 11101000, left 11100010, right 11100100. The first subframe after start-up and every 384th subframe after it (192 frames) use the start-of-block preamble. The other even subframes are left and the odd subframes are right.
- R5: `smp_ready` is 0 during reset. Otherwise it is high in exactly the clock before each subframe begins. The first subframe after start-up is left. A sample is taken at an edge where `smp_ready` and `smp_valid` are both high and `pdn` and `soft_rst` are both low. The line level of half-cell n of the stream (n = 0 at the start of the first subframe) appears on the pins at edge n+2 after start-up.
- R6: If `smp_valid` is low when a sample is due, the subframe carries a zero sample with V=1, U=0 and C=0.
- R7: Whenever the gate drives the pins, `tx_n` is the inverse of `tx_p`. When the gate does not drive, both pins are 0.
- R8: `tx_off` high at an edge forces both pins to 0 from that edge on. It does not stop or restart the encoder, so the stream resumes at its current position.
- R9: `pdn` or `soft_rst` high at an edge forces both pins to 0, closes the gate and returns the encoder to its start-up state. After the hold ends, the pins need a new rising edge on `fsync`.
- R10: With `bypass` high, the driven value of `tx_p` is `ext_bmc` as sampled at the previous edge. `tx_n` is its inverse, and the rules of R1, R8 and R9 still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (two clocks per slot) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down hold, active high |
| soft_rst | input | 1 | Software reset hold, active high |
| tx_off | input | 1 | Forces the pins low without disturbing the encoder |
| bypass | input | 1 | 1 selects `ext_bmc` as the line source |
| ext_bmc | input | 1 | Externally encoded line stream |
| fsync | input | 1 | Frame-sync clock; its rising edge opens the gate |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken at the next edge |
| smp_data | input | 24 | Audio sample |
| smp_v | input | 1 | Validity flag for the sample |
| smp_u | input | 1 | User bit for the sample |
| smp_c | input | 1 | Channel-status bit for the sample |
| tx_p | output | 1 | Line output, true polarity |
| tx_n | output | 1 | Line output, inverted polarity |

## Verification
The bench samples every result at the falling edge and advances a model by one step for each rising edge. It places each sample offered in the clock where `smp_ready` is high into a queue. It builds that sample's 64 half-cells two edges after the subframe begins, which is when the first half-cell reaches the pins. Control inputs (`tx_off`, `bypass`, `ext_bmc`, holds) are compared against the pins one edge after they were sampled. The gate opens one edge after an `fsync` rising edge is sampled and drives the pins one edge later. For each undisturbed subframe, the pins are also decoded back into the payload and checked for parity.

// File: rtl/bmc_tx_pkg.sv
`timescale 1ns/1ps
package bmc_tx_pkg;

  // Subframe format constants (fixed by the line format).
  localparam int SAMPLE_W   = 24;
  localparam int PRE_SLOTS  = 4;
  localparam int FLAG_BITS  = 4;                    // V, U, C, parity
  localparam int PAY_W      = SAMPLE_W + FLAG_BITS; // payload slots after preamble
  localparam int PRE_HALVES = 2 * PRE_SLOTS;

  typedef enum logic [1:0] {
    PRE_LEFT  = 2'd0,
    PRE_RIGHT = 2'd1,
    PRE_BLOCK = 2'd2
  } pre_e;

  // Eight half-cell shapes, first half-cell in bit 7, relative to a low start level.
  function automatic logic [PRE_HALVES-1:0] pre_shape(input pre_e kind);
    case (kind)
      PRE_BLOCK: pre_shape = 8'b1110_1000;
      PRE_RIGHT: pre_shape = 8'b1110_0100;
      default:   pre_shape = 8'b1110_0010;
    endcase
  endfunction

  // Level of preamble half-cell 'pos' given the level before the preamble.
  function automatic logic pre_level(input logic [PRE_HALVES-1:0] shape,
                                     input logic [2:0] pos,
                                     input logic base);
    pre_level = shape[3'd7 - pos] ^ base;
  endfunction

  // Biphase-mark: boundary always toggles, mid-cell toggles for a one.
  function automatic logic bmc_level(input logic prev, input logic bit_v,
                                     input logic second_half);
    bmc_level = second_half ? (prev ^ bit_v) : ~prev;
  endfunction

  // Payload in slot order (bit i = slot PRE_SLOTS+i) with even parity on top.
  function automatic logic [PAY_W-1:0] pack_payload(input logic [SAMPLE_W-1:0] smp,
                                                    input logic v, input logic u,
                                                    input logic c);
    logic [PAY_W-2:0] body;
    body = {c, u, v, smp};
    pack_payload = {^body, body};
  endfunction

endpackage

// File: rtl/bmc_sf_seq.sv
`timescale 1ns/1ps
module bmc_sf_seq
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int HALF_CELLS   = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hold,
  input  logic                          smp_valid,
  input  logic [SAMPLE_W-1:0]           smp_data,
  input  logic                          smp_v,
  input  logic                          smp_u,
  input  logic                          smp_c,
  output logic                          smp_ready,
  output logic                          at_load,
  output logic [$clog2(HALF_CELLS)-1:0] hc,
  output logic [PAY_W-1:0]              payload,
  output pre_e                          pre_kind
);
  localparam int HC_W  = $clog2(HALF_CELLS);
  localparam int FRM_W = $clog2(BLOCK_FRAMES);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_CELLS - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(BLOCK_FRAMES - 1);

  logic [HC_W-1:0]  hc_q;
  logic [FRM_W-1:0] frm_q;
  logic             right_q;   // channel of the next subframe to load
  logic [PAY_W-1:0] pay_q;
  pre_e             pre_q;
  logic [PAY_W-1:0] next_pay;
  pre_e             next_pre;

  assign at_load   = (hc_q == HC_LAST);
  assign smp_ready = at_load & rst_n;

  always_comb begin
    next_pay = smp_valid ? pack_payload(smp_data, smp_v, smp_u, smp_c)
                         : pack_payload('0, 1'b1, 1'b0, 1'b0);
    if (right_q)            next_pre = PRE_RIGHT;
    else if (frm_q == '0)   next_pre = PRE_BLOCK;
    else                    next_pre = PRE_LEFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q    <= HC_LAST;
      frm_q   <= '0;
      right_q <= 1'b0;
      pay_q   <= '0;
      pre_q   <= PRE_BLOCK;
    end else if (hold) begin
      hc_q    <= HC_LAST;
      frm_q   <= '0;
      right_q <= 1'b0;
      pay_q   <= '0;
      pre_q   <= PRE_BLOCK;
    end else begin
      hc_q <= at_load ? '0 : hc_q + 1'b1;
      if (at_load) begin
        pay_q   <= next_pay;
        pre_q   <= next_pre;
        right_q <= ~right_q;
        if (right_q) frm_q <= (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
      end
    end
  end

  assign hc       = hc_q;
  assign payload  = pay_q;
  assign pre_kind = pre_q;
endmodule

// File: rtl/bmc_cell.sv
`timescale 1ns/1ps
module bmc_cell
  import bmc_tx_pkg::*;
#(
  parameter int HALF_CELLS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hold,
  input  logic                          at_load,
  input  logic [$clog2(HALF_CELLS)-1:0] hc,
  input  logic [PAY_W-1:0]              payload,
  input  pre_e                          pre_kind,
  output logic                          cell_val
);
  localparam int HC_W   = $clog2(HALF_CELLS);
  localparam int SLOT_W = HC_W - 1;
  localparam logic [SLOT_W-1:0] PRE_END = SLOT_W'(PRE_SLOTS);

  logic              prev_q;   // level of the previous half-cell
  logic              base_q;   // level before the current preamble
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] pay_idx;
  logic [PAY_W-1:0]  pay_sh;
  logic              in_pre;
  logic              data_bit;

  assign slot     = hc[HC_W-1:1];
  assign in_pre   = (slot < PRE_END);
  assign pay_idx  = slot - PRE_END;
  assign pay_sh   = payload >> pay_idx;
  assign data_bit = pay_sh[0];

  assign cell_val = in_pre ? pre_level(pre_shape(pre_kind), hc[2:0], base_q)
                           : bmc_level(prev_q, data_bit, hc[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      base_q <= 1'b0;
    end else if (hold) begin
      prev_q <= 1'b0;
      base_q <= 1'b0;
    end else begin
      prev_q <= cell_val;
      if (at_load) base_q <= cell_val;
    end
  end
endmodule

// File: rtl/bmc_line_gate.sv
`timescale 1ns/1ps
module bmc_line_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tx_off,
  input  logic bypass,
  input  logic ext_bmc,
  input  logic fsync,
  input  logic cell_val,
  output logic gate_open,
  output logic drive_en,
  output logic tx_p,
  output logic tx_n
);
  logic fs_q;
  logic fs_rise;
  logic gate_q;
  logic src;
  logic p_q;
  logic n_q;

  assign fs_rise  = fsync & ~fs_q;
  assign drive_en = gate_q & ~tx_off & ~hold;
  assign src      = bypass ? ext_bmc : cell_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b1;
      gate_q <= 1'b0;
      p_q    <= 1'b0;
      n_q    <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (hold)         gate_q <= 1'b0;
      else if (fs_rise) gate_q <= 1'b1;
      p_q <= drive_en & src;
      n_q <= drive_en & ~src;
    end
  end

  assign gate_open = gate_q;
  assign tx_p      = p_q;
  assign tx_n      = n_q;
endmodule

// File: rtl/bmc_frame_tx.sv
`timescale 1ns/1ps
module bmc_frame_tx
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES   = 192,
  parameter int SUBFRAME_SLOTS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pdn,
  input  logic                soft_rst,
  input  logic                tx_off,
  input  logic                bypass,
  input  logic                ext_bmc,
  input  logic                fsync,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_v,
  input  logic                smp_u,
  input  logic                smp_c,
  output logic                tx_p,
  output logic                tx_n
);
  localparam int HALF_CELLS = 2 * SUBFRAME_SLOTS;
  localparam int HC_W       = $clog2(HALF_CELLS);

  logic             hold;
  logic             at_load;
  logic [HC_W-1:0]  hc;
  logic [PAY_W-1:0] payload;
  pre_e             pre_kind;
  logic             cell_val;
  logic             gate_open;
  logic             drive_en;
  logic             sf_first;

  assign hold     = pdn | soft_rst;
  assign sf_first = (hc == '0);

  bmc_sf_seq #(.BLOCK_FRAMES(BLOCK_FRAMES), .HALF_CELLS(HALF_CELLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_v(smp_v), .smp_u(smp_u), .smp_c(smp_c),
    .smp_ready(smp_ready), .at_load(at_load), .hc(hc),
    .payload(payload), .pre_kind(pre_kind)
  );

  bmc_cell #(.HALF_CELLS(HALF_CELLS)) u_cell (
    .clk(clk), .rst_n(rst_n), .hold(hold), .at_load(at_load),
    .hc(hc), .payload(payload), .pre_kind(pre_kind), .cell_val(cell_val)
  );

  bmc_line_gate u_gate (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tx_off(tx_off),
    .bypass(bypass), .ext_bmc(ext_bmc), .fsync(fsync), .cell_val(cell_val),
    .gate_open(gate_open), .drive_en(drive_en), .tx_p(tx_p), .tx_n(tx_n)
  );
endmodule

// File: rtl/bmc_frame_tx_chk.sv
`timescale 1ns/1ps
module bmc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pdn,
  input logic soft_rst,
  input logic tx_off,
  input logic fsync,
  input logic smp_ready,
  input logic tx_p,
  input logic tx_n,
  input logic gate_open,
  input logic drive_en,
  input logic sf_first
);
  // R1
  gate_opens_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> $past(fsync));

  // R1
  closed_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> (!tx_p && !tx_n));

  // R5
  ready_precedes_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !pdn && !soft_rst) |=> sf_first);

  // R7
  pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_p |-> !tx_n);

  // R7
  pins_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drive_en) |-> (tx_n == !tx_p));

  // R8
  txoff_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_off) |-> (!tx_p && !tx_n));

  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdn || soft_rst) |-> (!tx_p && !tx_n));

  // R9
  hold_closes_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn || soft_rst) |=> !gate_open);
endmodule

bind bmc_frame_tx bmc_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pdn(pdn), .soft_rst(soft_rst), .tx_off(tx_off),
  .fsync(fsync), .smp_ready(smp_ready), .tx_p(tx_p), .tx_n(tx_n),
  .gate_open(gate_open), .drive_en(drive_en), .sf_first(sf_first)
);

// File: tb/sim_bmc_frame_tx.sv
`timescale 1ns/1ps
module sim_bmc_frame_tx;
  localparam int LAST_CYC = 45000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, pdn = 1'b0, soft_rst = 1'b0, tx_off = 1'b0;
  logic        bypass = 1'b0, ext_bmc = 1'b0, fsync = 1'b0;
  logic        smp_valid = 1'b0, smp_v = 1'b0, smp_u = 1'b0, smp_c = 1'b0;
  logic [23:0] smp_data = '0;
  logic        smp_ready, tx_p, tx_n;

  always #2.5 clk = ~clk;

  bmc_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .soft_rst(soft_rst), .tx_off(tx_off),
    .bypass(bypass), .ext_bmc(ext_bmc), .fsync(fsync),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .smp_v(smp_v), .smp_u(smp_u), .smp_c(smp_c), .tx_p(tx_p), .tx_n(tx_n)
  );

  int  errs = 0, checks = 0, cyc = 0, k = -1, sub = 0;
  bit  done = 1'b0, gate_m = 1'b0, fsp_m = 1'b1, lvl = 1'b0, clean = 1'b0, uflow = 1'b0;
  bit  exp_half [64];
  bit  act_half [64];
  logic [27:0] cur_word = '0;
  logic [28:0] q [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // Slot i of the payload is slot 4+i: sample LSB first, then V, U, C, parity.
  function automatic logic [27:0] slots_of(input logic [23:0] d, input bit v,
                                           input bit u, input bit c);
    logic [27:0] w;
    int ones = 0;
    w = {1'b0, c, u, v, d};
    for (int i = 0; i < 27; i++) if (w[i]) ones++;
    w[27] = (ones % 2 == 1);
    return w;
  endfunction

  function automatic logic [7:0] pre_bits(input int s);
    if (s % 384 == 0)    return 8'b11101000;
    else if (s % 2 == 0) return 8'b11100010;
    else                 return 8'b11100100;
  endfunction

  task automatic build_subframe();
    logic [28:0] e;
    logic [7:0]  pat;
    bit          start, a;
    if (q.size() == 0) begin
      chk(1'b0, "R5", "no sample recorded for subframe", 0, 1);
      e = {1'b1, slots_of(24'd0, 1'b1, 1'b0, 1'b0)};
    end else e = q.pop_front();
    uflow = e[28];
    cur_word = e[27:0];
    pat = pre_bits(sub);
    start = lvl;
    for (int i = 0; i < 8; i++) exp_half[i] = pat[7-i] ^ start;
    lvl = exp_half[7];
    for (int s = 0; s < 28; s++) begin
      a = ~lvl;
      exp_half[8+2*s] = a;
      exp_half[9+2*s] = a ^ cur_word[s];
      lvl = exp_half[9+2*s];
    end
    clean = 1'b1;
  endtask

  task automatic decode_check();
    logic [27:0] dec;
    int ones = 0;
    for (int s = 0; s < 28; s++) begin
      dec[s] = act_half[8+2*s] ^ act_half[9+2*s];
      if (dec[s]) ones++;
    end
    chk(dec == cur_word, uflow ? "R6" : "R2", "decoded payload", int'(dec), int'(cur_word));
    chk(ones % 2 == 0, "R2", "even parity over slots 4..31", ones % 2, 0);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit drive, src, exp_p, exp_n;
      int h;
      string tag;
      h = 0;
      // ---------------- monitor: results of the edge just passed
      if (!rst_n || pdn || soft_rst) begin
        tag = !rst_n ? "R1" : "R9";
        chk(tx_p === 1'b0, tag, "tx_p held low", int'(tx_p), 0);
        chk(tx_n === 1'b0, tag, "tx_n held low", int'(tx_n), 0);
        chk(smp_ready === rst_n, "R5", "ready while reset or hold", int'(smp_ready), int'(rst_n));
        fsp_m = !rst_n ? 1'b1 : fsync;
        gate_m = 1'b0; k = -1; sub = 0; lvl = 1'b0; clean = 1'b0;
        q.delete();
      end else begin
        k++;
        drive = gate_m && !tx_off;
        if (k >= 1) begin
          h = (k - 1) % 64;
          if (h == 0) build_subframe();
          src = bypass ? ext_bmc : exp_half[h];
        end else src = bypass ? ext_bmc : 1'b0;
        exp_p = drive & src;
        exp_n = drive & ~src;
        if (!drive)            tag = tx_off ? "R8" : "R1";
        else if (bypass)       tag = "R10";
        else if (k < 1)        tag = "R1";
        else if (h < 8)        tag = "R4";
        else if (uflow)        tag = "R6";
        else                   tag = "R3";
        chk(tx_p === exp_p, tag, "tx_p line level", int'(tx_p), int'(exp_p));
        chk(tx_n === exp_n, "R7", "tx_n level", int'(tx_n), int'(exp_n));
        if (k >= 1) begin
          act_half[h] = tx_p;
          if (!(drive && !bypass)) clean = 1'b0;
          if (h == 63) begin
            if (clean) decode_check();
            sub++;
          end
        end
        if (fsync && !fsp_m) gate_m = 1'b1;
        fsp_m = fsync;
        chk(smp_ready === (k % 64 == 63), "R5", "ready timing", int'(smp_ready), int'(k % 64 == 63));
      end
      // ---------------- drive inputs for the next edge
      cyc++;
      rst_n    = (cyc >= 10);
      soft_rst = (cyc >= 12000 && cyc < 12005);
      pdn      = (cyc >= 15000 && cyc < 15030);
      tx_off   = (cyc >= 6000 && cyc < 6200);
      bypass   = (cyc >= 9000 && cyc < 9400);
      fsync    = (cyc >= 3 && cyc < 7) || ((cyc >= 200) && ((cyc / 64) % 2 == 1));
      ext_bmc  = 1'($urandom);
      smp_valid = (cyc < 20000) ? (($urandom % 10) != 0) : ((cyc / 640) % 5 != 2);
      smp_data = 24'($urandom);
      if (cyc % 1000 < 64) smp_data = (cyc % 2000 < 64) ? 24'hFFFFFF : 24'h000000;
      smp_v = 1'($urandom); smp_u = 1'($urandom); smp_c = 1'($urandom);
      if (rst_n && !pdn && !soft_rst && (k == -1 || k % 64 == 63))
        q.push_back(smp_valid ? {1'b0, slots_of(smp_data, smp_v, smp_u, smp_c)}
                              : {1'b1, slots_of(24'd0, 1'b1, 1'b0, 1'b0)});
      if (cyc >= LAST_CYC) done = 1'b1;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    wait (done);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d", cyc, LAST_CYC);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule